// File: doc/BRIEF.md
# Package Sleep Cache-Way Gating Controller

This controller decides when a multi-core package may drop into its deepest sleep level. It also sequences how the shared last-level cache ways are powered down before that level and brought back after it. Each core reports a two-bit sleep code. Once every core reports the deepest code, the controller drains the cache one group of ways at a time. For each group it asks the cache to flush those ways and waits for the acknowledgment. The package is declared asleep only when no way is left enabled. While asleep, the controller tells the fabric to stop sending snoops, because nothing cached remains.

A wake request, or any core leaving the deepest code, ends package sleep, and the cache stays fully off at that point. The controller then waits for a dwell period in which no core set sits in either of the two deepest levels. Only after that does it re-enable ways in small groups at a fixed pace, so the cache is not refilled just to be flushed again a moment later. A wake request during a partial drain stops the drain. Ways already flushed stay off, and the dwell period starts.

The flush interface is a request/acknowledge stream. `flush_req` acts as valid, with `flush_ways` as its payload, and `flush_done` acts as ready. Once raised, the request and its payload stay unchanged until the cycle in which `flush_done` is high; that cycle completes the transfer. The cache may hold `flush_done` low for as long as it needs, and the controller simply waits. The request is withdrawn without a transfer only when the drain is aborted. All other pins are plain levels.

Top module: `pkg_sleep_way_ctrl`

## Requirements
- R1: After reset, `way_en` is all ones, and `flush_req`, `pkg_deep` and `snoop_block` are low.
- R2: A drain starts at the clock edge where every core reports code 3 (deepest) and `wake_req` is low. One cycle later `flush_req` is high, and `flush_ways` holds the highest-numbered enabled ways, as many as the value of `shrink_step` sampled at that edge, with 0 counted as 1. Codes below 3 on any core, or a high `wake_req`, start nothing.
- R3: While `flush_done` is low and the drain continues, `flush_req` and `flush_ways` hold steady and `way_en` does not change. At the edge where `flush_done` is high, the offered ways are cleared from `way_en`, and the next group is offered in the following cycle if any way remains enabled.
- R4: `pkg_deep` and `snoop_block` rise in the cycle after the acknowledgment that leaves `way_en` zero. They stay high while all cores keep code 3 and `wake_req` is low, and they are never high while a way is enabled.
- R5: A high `wake_req`, or any core reporting a code other than 3, while the package is asleep drops `pkg_deep` and `snoop_block` one cycle later, with `way_en` still zero.
- R6: A high `wake_req` during a drain, with no acknowledgment in that cycle, drops `flush_req` one cycle later. Flushed ways stay disabled and unflushed ways stay enabled.
- R7: After leaving sleep or an aborted drain, `way_en` does not change until `DWELL_CYCLES` consecutive edges have passed without all cores reporting code 2 or higher. Any edge with all cores at code 2 or higher restarts that count, including during regrowth.
- R8: Regrowth adds the lowest-numbered disabled ways, `grow_step` of them with 0 counted as 1, every `GROW_INTERVAL` edges. The first step is visible `DWELL_CYCLES + GROW_INTERVAL` edges after the edge that starts the dwell count.
- R9: Regrowth ends with `way_en` all ones and no flush request. A new drain that starts from a partly enabled cache takes its groups from the ways still enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_state | input | 2*NUM_CORES | Sleep code per core, core c in bits [2c+1:2c]: 0 run, 1 light, 2 second-deepest, 3 deepest |
| wake_req | input | 1 | Package wake request |
| shrink_step | input | $clog2(NUM_WAYS)+1 | Ways per drain group, sampled when a drain starts |
| grow_step | input | $clog2(NUM_WAYS)+1 | Ways per regrowth step |
| flush_done | input | 1 | Flush acknowledgment (ready) |
| flush_req | output | 1 | Flush request (valid) |
| flush_ways | output | NUM_WAYS | Ways to flush in the current group |
| way_en | output | NUM_WAYS | Per-way enable mask |
| pkg_deep | output | 1 | Package in deepest sleep level |
| snoop_block | output | 1 | Snoops must not be sent |

## Verification
A drain start is seen one cycle after the edge that samples all cores at code 3. Each acknowledgment shows its cleared mask one cycle after its edge. The sleep flags rise together with the final mask and fall one cycle after the wake edge. The first regrowth step is due exactly `DWELL_CYCLES + GROW_INTERVAL` edges after the edge that starts or restarts the dwell count, and later steps follow every `GROW_INTERVAL` edges. The bench drives and samples only at falling edges, and it counts edges from the origin edge of each phase. It checks the mask for stability over the whole waiting window and checks the exact grown mask on the due edge.

// File: rtl/pkg_sleep_types_pkg.sv
package pkg_sleep_types_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_SHRINK,
    ST_DEEP,
    ST_DWELL,
    ST_GROW
  } pkg_state_e;

  localparam logic [1:0] CS_RUN   = 2'd0;
  localparam logic [1:0] CS_LIGHT = 2'd1;
  localparam logic [1:0] CS_MID   = 2'd2;
  localparam logic [1:0] CS_DEEP  = 2'd3;
endpackage

// File: rtl/sleep_way_pick.sv
// Selects up to `count` ways out of `avail` (0 treated as 1), starting from
// the highest or the lowest index depending on HIGH_FIRST.
module sleep_way_pick #(
  parameter int WAYS       = 16,
  parameter bit HIGH_FIRST = 1'b1,
  parameter int SW         = $clog2(WAYS) + 1
) (
  input  logic [WAYS-1:0] avail,
  input  logic [SW-1:0]   count,
  output logic [WAYS-1:0] pick
);
  logic [WAYS-1:0] ord_in;
  logic [WAYS-1:0] ord_out;
  logic [SW-1:0]   want;
  logic [SW-1:0]   taken;

  for (genvar i = 0; i < WAYS; i++) begin : g_order
    if (HIGH_FIRST) begin : g_high
      assign ord_in[i]          = avail[WAYS-1-i];
      assign pick[WAYS-1-i]     = ord_out[i];
    end else begin : g_low
      assign ord_in[i]          = avail[i];
      assign pick[i]            = ord_out[i];
    end
  end

  assign want = (count == '0) ? SW'(1) : count;

  always_comb begin
    taken   = '0;
    ord_out = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (ord_in[i] && (taken < want)) begin
        ord_out[i] = 1'b1;
        taken      = taken + SW'(1);
      end
    end
  end
endmodule

// File: rtl/sleep_cycle_counter.sv
// Free-running wrap counter; hit is high in the cycle the count reaches LIMIT-1.
module sleep_cycle_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign hit = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (hit)    cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/pkg_sleep_way_ctrl.sv
module pkg_sleep_way_ctrl
  import pkg_sleep_types_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int NUM_WAYS      = 16,
  parameter int DWELL_CYCLES  = 256,
  parameter int GROW_INTERVAL = 8,
  parameter int SW            = $clog2(NUM_WAYS) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NUM_CORES-1:0] core_state,
  input  logic                   wake_req,
  input  logic [SW-1:0]          shrink_step,
  input  logic [SW-1:0]          grow_step,
  input  logic                   flush_done,
  output logic                   flush_req,
  output logic [NUM_WAYS-1:0]    flush_ways,
  output logic [NUM_WAYS-1:0]    way_en,
  output logic                   pkg_deep,
  output logic                   snoop_block
);
  localparam logic [NUM_WAYS-1:0] ALL_WAYS = '1;

  pkg_state_e          state, nxt;
  logic [NUM_WAYS-1:0] way_nxt;
  logic [NUM_WAYS-1:0] shrink_pick, grow_pick;
  logic [SW-1:0]       n_q;
  logic [NUM_CORES-1:0] deep_c, mid_c;
  logic                all_deep, all_mid, enter, empty;
  logic                dwell_hit, grow_hit;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign deep_c[c] = (core_state[2*c +: 2] == CS_DEEP);
    assign mid_c[c]  = (core_state[2*c +: 2] >= CS_MID);
  end

  assign all_deep = &deep_c;
  assign all_mid  = &mid_c;
  assign enter    = all_deep && !wake_req;
  assign empty    = (way_en == '0);

  sleep_way_pick #(.WAYS(NUM_WAYS), .HIGH_FIRST(1'b1), .SW(SW)) u_shrink_pick (
    .avail (way_en),
    .count (n_q),
    .pick  (shrink_pick)
  );

  sleep_way_pick #(.WAYS(NUM_WAYS), .HIGH_FIRST(1'b0), .SW(SW)) u_grow_pick (
    .avail (~way_en),
    .count (grow_step),
    .pick  (grow_pick)
  );

  sleep_cycle_counter #(.LIMIT(DWELL_CYCLES)) u_dwell_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   ((state != ST_DWELL) || all_mid),
    .hit   (dwell_hit)
  );

  sleep_cycle_counter #(.LIMIT(GROW_INTERVAL)) u_grow_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state != ST_GROW),
    .hit   (grow_hit)
  );

  always_comb begin
    nxt     = state;
    way_nxt = way_en;
    unique case (state)
      ST_ACTIVE: if (enter) nxt = ST_SHRINK;
      ST_SHRINK: begin
        if (flush_done) way_nxt = way_en & ~shrink_pick;
        if (!enter)                nxt = ST_DWELL;
        else if (way_nxt == '0)    nxt = ST_DEEP;
      end
      ST_DEEP:   if (!enter) nxt = ST_DWELL;
      ST_DWELL: begin
        if (enter)                       nxt = empty ? ST_DEEP : ST_SHRINK;
        else if (!all_mid && dwell_hit)  nxt = ST_GROW;
      end
      ST_GROW: begin
        if (enter)        nxt = empty ? ST_DEEP : ST_SHRINK;
        else if (all_mid) nxt = ST_DWELL;
        else if (grow_hit) begin
          way_nxt = way_en | grow_pick;
          if (way_nxt == ALL_WAYS) nxt = ST_ACTIVE;
        end
      end
      default:   nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_ACTIVE;
      way_en <= ALL_WAYS;
      n_q    <= SW'(1);
    end else begin
      state  <= nxt;
      way_en <= way_nxt;
      if ((nxt == ST_SHRINK) && (state != ST_SHRINK)) n_q <= shrink_step;
    end
  end

  assign flush_req   = (state == ST_SHRINK);
  assign flush_ways  = flush_req ? shrink_pick : '0;
  assign pkg_deep    = (state == ST_DEEP);
  assign snoop_block = (state == ST_DEEP);
endmodule

// File: rtl/sleep_way_checker.sv
module sleep_way_checker #(
  parameter int NUM_CORES = 4,
  parameter int NUM_WAYS  = 16,
  parameter int SW        = $clog2(NUM_WAYS) + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2*NUM_CORES-1:0] core_state,
  input logic                   wake_req,
  input logic [SW-1:0]          grow_step,
  input logic                   flush_done,
  input logic                   flush_req,
  input logic [NUM_WAYS-1:0]    flush_ways,
  input logic [NUM_WAYS-1:0]    way_en,
  input logic                   pkg_deep,
  input logic                   snoop_block
);
  logic all_deep;
  assign all_deep = (core_state == {NUM_CORES{2'b11}});

  p_flush_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_done && all_deep && !wake_req) |=>
      (flush_req && $stable(flush_ways) && $stable(way_en)));

  p_flush_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && flush_done) |=> (way_en == ($past(way_en) & ~$past(flush_ways))));

  p_no_gain_in_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> ((way_en & ~$past(way_en)) == '0));

  p_deep_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_deep || snoop_block) |-> (way_en == '0));

  p_deep_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkg_deep) |-> $past(all_deep && !wake_req));

  p_deep_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkg_deep && (wake_req || !all_deep)) |=> (!pkg_deep && !snoop_block && way_en == '0));

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && wake_req && !flush_done) |=> (!flush_req && $stable(way_en)));

  p_no_regrow_after_deep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkg_deep |=> ((way_en & ~$past(way_en)) == '0));

  p_grow_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((way_en & ~$past(way_en)) != '0) |->
      ($countones(way_en & ~$past(way_en)) <=
       (($past(grow_step) == '0) ? 1 : int'($past(grow_step)))));
endmodule

bind pkg_sleep_way_ctrl sleep_way_checker #(
  .NUM_CORES (NUM_CORES),
  .NUM_WAYS  (NUM_WAYS),
  .SW        (SW)
) u_sleep_way_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_state  (core_state),
  .wake_req    (wake_req),
  .grow_step   (grow_step),
  .flush_done  (flush_done),
  .flush_req   (flush_req),
  .flush_ways  (flush_ways),
  .way_en      (way_en),
  .pkg_deep    (pkg_deep),
  .snoop_block (snoop_block)
);

// File: tb/test_pkg_sleep_way_ctrl.sv
`timescale 1ns/1ps
module test_pkg_sleep_way_ctrl;
  localparam int NC = 4;
  localparam int W  = 16;
  localparam int D  = 12;
  localparam int G  = 3;
  localparam int SW = $clog2(W) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2*NC-1:0] core_state;
  logic          wake_req, flush_done;
  logic [SW-1:0] shrink_step, grow_step;
  logic          flush_req, pkg_deep, snoop_block;
  logic [W-1:0]  flush_ways, way_en;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] em;

  always #2.5 clk = ~clk;

  pkg_sleep_way_ctrl #(
    .NUM_CORES(NC), .NUM_WAYS(W), .DWELL_CYCLES(D), .GROW_INTERVAL(G)
  ) i_pkg_sleep_way_ctrl (
    .clk(clk), .rst_n(rst_n), .core_state(core_state), .wake_req(wake_req),
    .shrink_step(shrink_step), .grow_step(grow_step), .flush_done(flush_done),
    .flush_req(flush_req), .flush_ways(flush_ways), .way_en(way_en),
    .pkg_deep(pkg_deep), .snoop_block(snoop_block)
  );

  function automatic logic [W-1:0] pick(input logic [W-1:0] avail, input int k, input bit high);
    int want = (k == 0) ? 1 : k;
    int got = 0;
    pick = '0;
    for (int i = 0; i < W; i++) begin
      int idx = high ? (W - 1 - i) : i;
      if (avail[idx] && got < want) begin
        pick[idx] = 1'b1;
        got++;
      end
    end
  endfunction

  function automatic logic [2*NC-1:0] all_code(input logic [1:0] c);
    return {NC{c}};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drains from the expected mask em; stops after `stop` groups if stop >= 0.
  task automatic do_shrink(input int k, input int stop);
    int groups = 0;
    core_state  = all_code(2'd3);
    shrink_step = SW'(k);
    tick();
    shrink_step = SW'($urandom % 17);
    while (em != '0 && (stop < 0 || groups < stop)) begin
      logic [W-1:0] exp_w = pick(em, k, 1'b1);
      int d = $urandom % 4;
      bit ok = 1'b1;
      chk(flush_req && flush_ways == exp_w, groups == 0 ? "R2 first group" : "R3 next group",
          {15'd0, flush_req, flush_ways}, {15'd0, 1'b1, exp_w});
      for (int j = 0; j < d; j++) begin
        tick();
        if (!flush_req || flush_ways != exp_w || way_en != em) ok = 1'b0;
      end
      if (d > 0) chk(ok, "R3 hold while not acknowledged", {16'd0, flush_ways}, {16'd0, exp_w});
      flush_done = 1'b1;
      tick();
      flush_done = 1'b0;
      em &= ~exp_w;
      groups++;
      chk(way_en == em, "R3 mask after acknowledge", {16'd0, way_en}, {16'd0, em});
      if (em != '0) chk(!pkg_deep && !snoop_block, "R4 not asleep with ways on",
                         {30'd0, pkg_deep, snoop_block}, 32'd0);
    end
    if (em == '0) chk(pkg_deep && snoop_block, "R4 asleep after last group",
                      {30'd0, pkg_deep, snoop_block}, 32'd3);
  endtask

  // Called at the falling edge right after the origin edge of a dwell count.
  task automatic wait_first_grow(input int g);
    bit ok = 1'b1;
    for (int j = 1; j < D + G; j++) begin
      tick();
      if (way_en != em || flush_req) ok = 1'b0;
    end
    chk(ok, "R7 mask held through dwell", {16'd0, way_en}, {16'd0, em});
    tick();
    em |= pick(~em, g, 1'b0);
    chk(way_en == em, "R8 first regrowth step", {16'd0, way_en}, {16'd0, em});
  endtask

  task automatic regrow(input int g, input int hiccup);
    grow_step = SW'(g);
    if (hiccup == 1) begin
      repeat (4) tick();
      core_state = all_code(2'd2);
      tick();
      core_state = all_code(2'd0);
    end
    wait_first_grow(g);
    if (hiccup == 2 && em != '1) begin
      core_state = all_code(2'd2);
      tick();
      core_state = all_code(2'd0);
      wait_first_grow(g);
    end
    while (em != '1) begin
      bit ok = 1'b1;
      for (int j = 1; j < G; j++) begin
        tick();
        if (way_en != em) ok = 1'b0;
      end
      chk(ok, "R8 mask held between steps", {16'd0, way_en}, {16'd0, em});
      tick();
      em |= pick(~em, g, 1'b0);
      chk(way_en == em, "R8 regrowth step", {16'd0, way_en}, {16'd0, em});
    end
    repeat (3) tick();
    chk(way_en == '1 && !flush_req && !pkg_deep, "R9 full cache, no request",
        {15'd0, flush_req, way_en}, {16'd0, 16'hffff});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; core_state = '0; wake_req = 1'b0; flush_done = 1'b0;
    shrink_step = '0; grow_step = '0;
    em = '1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(way_en == '1, "R1 mask all on", {16'd0, way_en}, 32'h0000ffff);
    chk(!flush_req && !pkg_deep && !snoop_block, "R1 flags low",
        {29'd0, flush_req, pkg_deep, snoop_block}, 32'd0);

    // R2: second-deepest on all cores, or deepest with wake, starts nothing.
    core_state = all_code(2'd2);
    repeat (5) tick();
    chk(!flush_req && way_en == '1, "R2 code 2 ignored", {15'd0, flush_req, way_en}, 32'h0000ffff);
    core_state = all_code(2'd3);
    wake_req = 1'b1;
    repeat (5) tick();
    chk(!flush_req && way_en == '1, "R2 wake blocks drain", {15'd0, flush_req, way_en}, 32'h0000ffff);
    wake_req = 1'b0;
    core_state = all_code(2'd0);
    tick();

    // Random entries with random group sizes, acknowledgment delays and exit causes.
    for (int it = 0; it < 6; it++) begin
      int k = (it == 0) ? 0 : (it == 1) ? 16 : int'($urandom % 17);
      int g = (it == 2) ? 0 : int'($urandom % 6);
      int hold = 1 + int'($urandom % 4);
      bit ok = 1'b1;
      do_shrink(k, -1);
      for (int j = 0; j < hold; j++) begin
        tick();
        if (!pkg_deep || !snoop_block) ok = 1'b0;
      end
      chk(ok, "R4 stays asleep", {30'd0, pkg_deep, snoop_block}, 32'd3);
      if (it % 2 == 0) wake_req = 1'b1;
      else core_state[1:0] = 2'd1;
      tick();
      chk(!pkg_deep && !snoop_block && way_en == '0, "R5 exit with cache off",
          {14'd0, pkg_deep, snoop_block, way_en}, 32'd0);
      wake_req = 1'b0;
      core_state = all_code(2'd0);
      regrow(g, it % 3);
    end

    // R6 abort mid-drain, then R9 new drain from the partial mask.
    do_shrink(4, 1);
    chk(flush_req && flush_ways == 16'h0f00, "R3 second group pending",
        {15'd0, flush_req, flush_ways}, {15'd0, 1'b1, 16'h0f00});
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    chk(!flush_req && way_en == 16'h0fff, "R6 abort keeps flushed ways off",
        {15'd0, flush_req, way_en}, 32'h00000fff);
    do_shrink(5, -1);
    chk(em == '0, "R9 drain from partial mask completes", {16'd0, em}, 32'd0);
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    core_state = all_code(2'd0);
    regrow(7, 0);

    // Abort, then regrow from the partial mask.
    do_shrink(4, 1);
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    core_state = all_code(2'd0);
    chk(way_en == 16'h0fff && !flush_req, "R6 abort second case", {15'd0, flush_req, way_en}, 32'h00000fff);
    regrow(3, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule